// File: doc/BRIEF.md
# Stack pointer with interrupt lockout

This block holds a 16-bit stack pointer. Software sees it as two byte-wide I/O registers, a high half and a low half, and can read and write both. The processor core can also move it with push, pop, call and return requests. A call or return moves the pointer by the size of a return address, which is 2 or 3 bytes. Only the pointer bits needed to reach the configured data memory are kept. The other bits read as zero, and writes to them have no effect.

Software usually rewrites the pointer one byte at a time. An interrupt taken between the two writes would push its return address through a half-updated pointer. To stop this, a write to the low byte raises an interrupt-block output. The output drops after four completed instructions, or sooner, at the next write to any I/O location. The interrupt controller, the memory accesses made at the pointer address and instruction decoding all sit outside this block.

Top module: `stack_ptr_guard`

## Requirements
- R1: The pointer `sp_value` is 16 bits wide. Bits 15:8 are the high byte register and bits 7:0 are the low byte register. A software write (`io_we` high with `io_sel_hi` or `io_sel_lo` high) loads `io_wdata` into the selected byte or bytes, and the new value appears on `sp_value` one clock later.
- R2: Only the lowest `SP_BITS` bits (default 14) are implemented. Bits at or above `SP_BITS` always read as zero, and writes to them are ignored.
- R3: After reset, `sp_value` equals `RAM_TOP` masked to the implemented bits (default 16'h3FFF) and `irq_block` is low.
- R4: A low-byte write sets `irq_block` high from the next cycle. It stays high until four `instr_done` strobes have been seen after the write cycle, and falls in the cycle after the fourth strobe. A strobe in the same cycle as the write is not counted. `irq_block` never rises without a low-byte write.
- R5: While `irq_block` is high, any I/O write that does not target the low byte (`io_we` high, `io_sel_lo` low) drops `irq_block` in the next cycle. This includes a write to the high byte.
- R6: A low-byte write while `irq_block` is already high restarts the count at four.
- R7: A push request lowers the pointer by one and a pop request raises it by one, wrapping within the implemented bits.
- R8: A call request lowers the pointer by `RET_BYTES` (default 2) and a return request raises it by `RET_BYTES`, wrapping within the implemented bits.
- R9: A software write takes priority over any hardware request in the same cycle. Among hardware requests made together, the order of priority is push, then pop, then call, then return.
- R10: With no software write and no hardware request, the pointer holds its value. `instr_done` and I/O writes to other locations leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| io_we | input | 1 | Strobe for a write to any I/O-space location |
| io_sel_lo | input | 1 | The current I/O write targets the low pointer byte |
| io_sel_hi | input | 1 | The current I/O write targets the high pointer byte |
| io_wdata | input | 8 | I/O write data |
| instr_done | input | 1 | Instruction-completion strobe |
| push_req | input | 1 | Decrement the pointer by one |
| pop_req | input | 1 | Increment the pointer by one |
| call_req | input | 1 | Decrement the pointer by the return-address size |
| ret_req | input | 1 | Increment the pointer by the return-address size |
| sp_value | output | 16 | Current pointer value; the high and low bytes are the two readable registers |
| irq_block | output | 1 | Interrupt acceptance must be held off while high |

## Verification
The lockout window is driven in three ways. A plain run of four completions tells a correct count from an off-by-one. A run cut short by an unrelated I/O write shows the early exit. A second low write placed mid-window shows the restart, which a missing reload would give away. Pointer writes with all ones in the high byte show whether the unimplemented bits are masked. Each hardware request is applied alone, at zero and at the top of the range, to check step size and wrap-around. Requests are also applied together and against a software write, to show the priority order.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;

  // Mask with the lowest 'bits' bits set, capped at 16.
  function automatic logic [15:0] low_mask(int unsigned bits);
    logic [15:0] m;
    m = '0;
    for (int i = 0; i < 16; i++) begin
      if (i < bits) m[i] = 1'b1;
    end
    return m;
  endfunction

  typedef enum logic [2:0] {
    ADJ_NONE,
    ADJ_PUSH,
    ADJ_POP,
    ADJ_CALL,
    ADJ_RET
  } adj_op_e;

endpackage

// File: rtl/stkptr_adjust.sv
module stkptr_adjust
  import stkptr_pkg::*;
#(
  parameter logic [15:0] MASK      = 16'h3FFF,
  parameter int unsigned RET_BYTES = 2
) (
  input  logic        push_req,
  input  logic        pop_req,
  input  logic        call_req,
  input  logic        ret_req,
  input  logic [15:0] sp_q,
  output logic        adj_en,
  output logic [15:0] sp_adj
);

  localparam logic [15:0] RET_STEP = 16'(RET_BYTES);

  adj_op_e op;

  // Fixed priority among hardware requests.
  always_comb begin
    if (push_req)      op = ADJ_PUSH;
    else if (pop_req)  op = ADJ_POP;
    else if (call_req) op = ADJ_CALL;
    else if (ret_req)  op = ADJ_RET;
    else               op = ADJ_NONE;
  end

  always_comb begin
    adj_en = (op != ADJ_NONE);
    unique case (op)
      ADJ_PUSH: sp_adj = (sp_q - 16'd1) & MASK;
      ADJ_POP:  sp_adj = (sp_q + 16'd1) & MASK;
      ADJ_CALL: sp_adj = (sp_q - RET_STEP) & MASK;
      ADJ_RET:  sp_adj = (sp_q + RET_STEP) & MASK;
      default:  sp_adj = sp_q;
    endcase
  end

endmodule

// File: rtl/stkptr_ptr_reg.sv
module stkptr_ptr_reg #(
  parameter logic [15:0] MASK      = 16'h3FFF,
  parameter logic [15:0] RESET_VAL = 16'h3FFF,
  parameter int unsigned LANES     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_we,
  input  logic [7:0]       wdata,
  input  logic             hw_en,
  input  logic [15:0]      hw_val,
  output logic [15:0]      sp_q
);

  logic [15:0] sw_val;
  logic [15:0] sp_d;
  logic        sw_en;
  logic        load_en;

  // One byte lane per software-visible register.
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_comb begin
      sw_val[b*8 +: 8] = lane_we[b] ? wdata : sp_q[b*8 +: 8];
    end
  end

  always_comb begin
    sw_en   = |lane_we;
    load_en = sw_en | hw_en;
    if (sw_en)      sp_d = sw_val & MASK;
    else if (hw_en) sp_d = hw_val & MASK;
    else            sp_d = sp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= RESET_VAL & MASK;
    end else if (load_en) begin
      sp_q <= sp_d;
    end
  end

endmodule

// File: rtl/stkptr_lockout.sv
module stkptr_lockout #(
  parameter int unsigned WINDOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic io_we,
  input  logic instr_done,
  output logic blocked
);

  localparam int unsigned CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] WIN = CW'(WINDOW);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          active;
  logic          cnt_en;

  always_comb begin
    active = (cnt_q != '0);
    cnt_en = arm | (active & (io_we | instr_done));
    if (arm)                      cnt_d = WIN;
    else if (active && io_we)     cnt_d = '0;
    else if (active && instr_done) cnt_d = cnt_q - ONE;
    else                          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign blocked = active;

endmodule

// File: rtl/stack_ptr_guard.sv
module stack_ptr_guard
  import stkptr_pkg::*;
#(
  parameter logic [15:0] RAM_TOP     = 16'h3FFF,
  parameter int unsigned SP_BITS     = 14,
  parameter int unsigned RET_BYTES   = 2,
  parameter int unsigned LOCK_INSTRS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_we,
  input  logic        io_sel_lo,
  input  logic        io_sel_hi,
  input  logic [7:0]  io_wdata,
  input  logic        instr_done,
  input  logic        push_req,
  input  logic        pop_req,
  input  logic        call_req,
  input  logic        ret_req,
  output logic [15:0] sp_value,
  output logic        irq_block
);

  localparam logic [15:0] SP_MASK = low_mask(SP_BITS);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic [1:0]  lane_we;
  logic        hw_en;
  logic [15:0] hw_val;

  assign lane_we = {io_we & io_sel_hi, io_we & io_sel_lo};

  stkptr_adjust #(
    .MASK      (SP_MASK),
    .RET_BYTES (RET_BYTES)
  ) u_adjust (
    .push_req (push_req),
    .pop_req  (pop_req),
    .call_req (call_req),
    .ret_req  (ret_req),
    .sp_q     (sp_value),
    .adj_en   (hw_en),
    .sp_adj   (hw_val)
  );

  stkptr_ptr_reg #(
    .MASK      (SP_MASK),
    .RESET_VAL (RAM_TOP),
    .LANES     (2)
  ) u_ptr (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .lane_we (lane_we),
    .wdata   (io_wdata),
    .hw_en   (hw_en),
    .hw_val  (hw_val),
    .sp_q    (sp_value)
  );

  stkptr_lockout #(
    .WINDOW (LOCK_INSTRS)
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .arm        (lane_we[0]),
    .io_we      (io_we),
    .instr_done (instr_done),
    .blocked    (irq_block)
  );

endmodule

// File: rtl/stack_ptr_guard_chk.sv
module stack_ptr_guard_chk #(
  parameter logic [15:0] MASK      = 16'h3FFF,
  parameter int unsigned RET_BYTES = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        io_we,
  input logic        io_sel_lo,
  input logic        io_sel_hi,
  input logic [7:0]  io_wdata,
  input logic        push_req,
  input logic        pop_req,
  input logic        call_req,
  input logic        ret_req,
  input logic [15:0] sp_value,
  input logic        irq_block
);

  localparam logic [15:0] RSTEP = 16'(RET_BYTES);

  logic sw_wr;
  logic lo_wr;
  logic any_hw;
  assign lo_wr  = io_we & io_sel_lo;
  assign sw_wr  = io_we & (io_sel_lo | io_sel_hi);
  assign any_hw = push_req | pop_req | call_req | ret_req;

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_value & ~MASK) == 16'h0000); // R2

  AST_BLOCK_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> irq_block); // R4

  AST_NO_SPURIOUS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_block && !lo_wr) |=> !irq_block); // R4

  AST_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_block && io_we && !io_sel_lo) |=> !irq_block); // R5

  AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !io_sel_hi) |=> sp_value[7:0] == ($past(io_wdata) & MASK[7:0])); // R9

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && push_req) |=> sp_value == (($past(sp_value) - 16'd1) & MASK)); // R7

  AST_CALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !push_req && !pop_req && call_req)
      |=> sp_value == (($past(sp_value) - RSTEP) & MASK)); // R8

  AST_RET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !push_req && !pop_req && !call_req && ret_req)
      |=> sp_value == (($past(sp_value) + RSTEP) & MASK)); // R8

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !any_hw) |=> $stable(sp_value)); // R10

endmodule

bind stack_ptr_guard stack_ptr_guard_chk #(
  .MASK      (SP_MASK),
  .RET_BYTES (RET_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .io_we     (io_we),
  .io_sel_lo (io_sel_lo),
  .io_sel_hi (io_sel_hi),
  .io_wdata  (io_wdata),
  .push_req  (push_req),
  .pop_req   (pop_req),
  .call_req  (call_req),
  .ret_req   (ret_req),
  .sp_value  (sp_value),
  .irq_block (irq_block)
);

// File: tb/stack_ptr_guard_test.sv
module stack_ptr_guard_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] MASK = 16'h3FFF;
  localparam logic [15:0] RSTEP = 16'd2;

  logic        clk;
  logic        rst_n;
  logic        io_we, io_sel_lo, io_sel_hi;
  logic [7:0]  io_wdata;
  logic        instr_done;
  logic        push_req, pop_req, call_req, ret_req;
  logic [15:0] sp_value;
  logic        irq_block;

  int total;
  int bad;
  bit finished;

  stack_ptr_guard uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_we      (io_we),
    .io_sel_lo  (io_sel_lo),
    .io_sel_hi  (io_sel_hi),
    .io_wdata   (io_wdata),
    .instr_done (instr_done),
    .push_req   (push_req),
    .pop_req    (pop_req),
    .call_req   (call_req),
    .ret_req    (ret_req),
    .sp_value   (sp_value),
    .irq_block  (irq_block)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Inputs change just after a falling edge; results are read at the next falling edge.
  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clear_in();
    io_we = 0; io_sel_lo = 0; io_sel_hi = 0; io_wdata = 8'h00;
    instr_done = 0; push_req = 0; pop_req = 0; call_req = 0; ret_req = 0;
  endtask

  task automatic sw_wr(logic lo, logic hi, logic [7:0] d);
    io_we = 1; io_sel_lo = lo; io_sel_hi = hi; io_wdata = d;
    cyc();
    clear_in();
  endtask

  task automatic other_wr();
    io_we = 1; io_wdata = 8'hA5;
    cyc();
    clear_in();
  endtask

  task automatic instr();
    instr_done = 1;
    cyc();
    clear_in();
  endtask

  task automatic set_sp(logic [15:0] v);
    sw_wr(1'b1, 1'b1, v[7:0]);   // both bytes at once first
    sw_wr(1'b0, 1'b1, v[15:8]);  // high byte, also ends the block
  endtask

  task automatic t_reset();
    chk("R3 reset pointer", sp_value, 16'h3FFF & MASK);
    chk("R3 reset block", {15'd0, irq_block}, 16'd0);
  endtask

  task automatic t_bytes();
    sw_wr(1'b1, 1'b0, 8'h34);
    chk("R1 low byte write", sp_value, 16'h3F34);
    sw_wr(1'b0, 1'b1, 8'h12);
    chk("R1 high byte write", sp_value, 16'h1234);
    sw_wr(1'b0, 1'b1, 8'hC5);
    chk("R2 upper bits ignored", sp_value, 16'h0534);
    sw_wr(1'b1, 1'b1, 8'hFF);
    chk("R2 both bytes all ones", sp_value, 16'h3FFF);
  endtask

  task automatic t_lock_full();
    other_wr();
    chk("R5 clear before test", {15'd0, irq_block}, 16'd0);
    other_wr();
    chk("R4 other write does not block", {15'd0, irq_block}, 16'd0);
    io_we = 1; io_sel_lo = 1; io_wdata = 8'h10; instr_done = 1;
    cyc();
    clear_in();
    chk("R4 block after low write", {15'd0, irq_block}, 16'd1);
    for (int i = 1; i <= 3; i++) begin
      instr();
      chk("R4 block held", {15'd0, irq_block}, 16'd1);
    end
    cyc();
    chk("R4 idle cycle holds block", {15'd0, irq_block}, 16'd1);
    instr();
    chk("R4 block ends after fourth", {15'd0, irq_block}, 16'd0);
  endtask

  task automatic t_lock_early();
    sw_wr(1'b1, 1'b0, 8'h20);
    instr();
    chk("R5 still blocked", {15'd0, irq_block}, 16'd1);
    other_wr();
    chk("R5 early end on io write", {15'd0, irq_block}, 16'd0);
    sw_wr(1'b1, 1'b0, 8'h22);
    sw_wr(1'b0, 1'b1, 8'h01);
    chk("R5 high byte write ends block", {15'd0, irq_block}, 16'd0);
    chk("R10 io writes keep pointer", sp_value, 16'h0122);
  endtask

  task automatic t_lock_restart();
    sw_wr(1'b1, 1'b0, 8'h30);
    instr();
    instr();
    sw_wr(1'b1, 1'b0, 8'h31);
    for (int i = 1; i <= 3; i++) instr();
    chk("R6 restart keeps block", {15'd0, irq_block}, 16'd1);
    instr();
    chk("R6 block ends after restart", {15'd0, irq_block}, 16'd0);
  endtask

  task automatic t_hw();
    set_sp(16'h0100);
    chk("R1 set pointer", sp_value, 16'h0100);
    push_req = 1; cyc(); clear_in();
    chk("R7 push", sp_value, 16'h00FF);
    pop_req = 1; cyc(); clear_in();
    chk("R7 pop", sp_value, 16'h0100);
    call_req = 1; cyc(); clear_in();
    chk("R8 call", sp_value, 16'h0100 - RSTEP);
    ret_req = 1; cyc(); clear_in();
    chk("R8 return", sp_value, 16'h0100);
    set_sp(16'h0000);
    push_req = 1; cyc(); clear_in();
    chk("R7 push wraps", sp_value, 16'h3FFF);
    ret_req = 1; cyc(); clear_in();
    chk("R8 return wraps", sp_value, (16'h3FFF + RSTEP) & MASK);
    call_req = 1; cyc(); clear_in();
    chk("R8 call wraps", sp_value, 16'h3FFF);
  endtask

  task automatic t_prio();
    set_sp(16'h0100);
    io_we = 1; io_sel_lo = 1; io_wdata = 8'h55; push_req = 1;
    cyc(); clear_in();
    chk("R9 sw over push", sp_value, 16'h0155);
    push_req = 1; call_req = 1; cyc(); clear_in();
    chk("R9 push over call", sp_value, 16'h0154);
    pop_req = 1; ret_req = 1; call_req = 1; cyc(); clear_in();
    chk("R9 pop over call and ret", sp_value, 16'h0155);
    call_req = 1; ret_req = 1; cyc(); clear_in();
    chk("R9 call over ret", sp_value, 16'h0155 - RSTEP);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) begin
      instr();
      chk("R10 instr_done holds pointer", sp_value, 16'h0153);
    end
  endtask

  initial begin
    total = 0; bad = 0; finished = 0;
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_bytes();
    t_lock_full();
    t_lock_early();
    t_lock_restart();
    t_hw();
    t_prio();
    t_hold();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule